// File: doc/BRIEF.md
# Compare/Capture Event Timer

An up-counting timer with a small synchronous register bus. Once started, the counter advances by one on every functional tick. A tick is either every clock or one per 2^(v+1) clocks, where v comes from the prescaler field. When the counter passes its all-ones value it either takes a reload value or stops at zero.

A match register can raise an event as the counter steps onto it. A capture register latches the running count when a chosen edge appears on a synchronised input pin. A waveform pin reacts to overflow, or to overflow and match, either as a one-cycle pulse or by toggling, and it rests at a programmable idle level.

Match, overflow and capture each set a sticky status flag. Software clears a flag by writing a one to it. An interrupt line is raised while any flag is set whose enable bit is also set. A register write is taken on the rising clock edge at which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `cmpcap_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `pwm_out` are low. The register word addresses are: 0 control, 1 counter, 2 reload value, 3 match, 4 captured count (read only), 5 status, 6 interrupt enable.
- R2: Control bit 0 (run) makes the counter add one per tick. With run clear, the counter holds its value.
- R3: With control bit 5 set, a tick occurs once per 2^(v+1) clocks, where v is control bits 4:2. Ticks start counting from the edge that set run. With bit 5 clear, every clock is a tick.
- R4: A tick at 0xFFFFFFFF sets status bit 1 (overflow). If control bit 1 (auto-reload) is set, the counter then takes the reload value. Otherwise it goes to 0 and the run bit clears.
- R5: With control bit 6 set, a tick that moves the counter onto the match value sets status bit 0 (match). This includes a reload onto that value. With bit 6 clear, no match is flagged.
- R6: A write to the counter register loads it at that edge, and the load replaces that cycle's increment.
- R7: Control bits 9:8 pick the capture edge: 0 none, 1 rising, 2 falling, 3 both. The input passes two synchronising flops, so a qualifying change is captured at the third rising edge after it. The capture stores the count in register 4 and sets status bit 2.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. A new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit and its enable bit (same position in register 6) are both 1.
- R10: Control bits 11:10 choose the waveform trigger: 0 none, 1 overflow, 2 overflow or match. Value 3 acts as none.
- R11: With control bit 12 clear, a trigger makes `pwm_out` leave its idle level for one cycle. With bit 12 set, each trigger toggles it. The waveform state changes at the same edge as the event's flag.
- R12: Control bit 7 is the idle level. `pwm_out` shows the waveform state XOR this bit, and the state is cleared while no trigger is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Timer waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- each tick advances the count by one, and without a tick or a counter write the count holds;
- an overflow lands on the reload value or zero, according to auto-reload;
- every overflow, match and capture event shows up in its status flag on the next cycle, and a capture also holds the count of the cycle before;
- a pulse-mode waveform never stays active without a trigger;
- the interrupt is quiet with no flags set.

Only the bench scenarios can show the externally visible outcomes:
- the actual prescaler ratios;
- which edge mode accepts which input transition, and the three-edge capture latency;
- that the trigger selection masks match events and treats value 3 as none;
- the toggle sequence and the idle-level inversion.

// File: rtl/cct_pkg.sv
package cct_pkg;
  // control word layout
  localparam int CTL_W      = 13;
  localparam int CB_RUN     = 0;
  localparam int CB_AR      = 1;
  localparam int CB_DIV_LO  = 2;
  localparam int DIV_FLD_W  = 3;
  localparam int CB_DIV_EN  = 5;
  localparam int CB_CMP_EN  = 6;
  localparam int CB_IDLE    = 7;
  localparam int CB_EDGE_LO = 8;
  localparam int CB_TRG_LO  = 10;
  localparam int CB_TOGGLE  = 12;

  // register word addresses
  localparam int RA_CTL  = 0;
  localparam int RA_CNT  = 1;
  localparam int RA_LOAD = 2;
  localparam int RA_MAT  = 3;
  localparam int RA_CAPT = 4;
  localparam int RA_STAT = 5;
  localparam int RA_IEN  = 6;

  // status flag positions
  localparam int NFLAG    = 3;
  localparam int FL_MATCH = 0;
  localparam int FL_OVF   = 1;
  localparam int FL_CAP   = 2;

  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_sel_e;
  typedef enum logic [1:0] {TRG_NONE, TRG_OVF, TRG_OVF_MAT, TRG_RSVD} trig_sel_e;

  // clocks per tick for a prescaler field value
  function automatic int unsigned div_ratio(input int unsigned v);
    return 32'd1 << (v + 1);
  endfunction

  function automatic logic edge_hit(input edge_sel_e m, input logic rise, input logic fall);
    case (m)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic trig_hit(input trig_sel_e t, input logic ovf, input logic mat);
    case (t)
      TRG_OVF:     return ovf;
      TRG_OVF_MAT: return ovf | mat;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic trig_active(input trig_sel_e t);
    return (t == TRG_OVF) || (t == TRG_OVF_MAT);
  endfunction
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale
  import cct_pkg::*;
#(
  parameter int FLD_W = DIV_FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_en,
  input  logic [FLD_W-1:0] div_sel,
  output logic             tick
);
  localparam int PC_W = 1 << FLD_W;

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] last;
  logic            at_last;

  always_comb begin
    last    = PC_W'(div_ratio(32'(div_sel)) - 1);
    at_last = (pcnt_q == last);
    tick    = run & (~div_en | at_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt_q <= '0;
    else if (!run || !div_en)  pcnt_q <= '0;
    else if (at_last)          pcnt_q <= '0;
    else                       pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture
  import cct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e mode,
  output logic      cap_evt
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    rise    = s2_q & ~s3_q;
    fall    = ~s2_q & s3_q;
    cap_evt = edge_hit(mode, rise, fall);
  end
endmodule

// File: rtl/cct_wave.sv
module cct_wave
  import cct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trig_sel_e trg,
  input  logic      toggle,
  input  logic      idle_lvl,
  input  logic      ovf_evt,
  input  logic      mat_evt,
  output logic      trig_evt,
  output logic      wave_q,
  output logic      pwm_out
);
  always_comb trig_evt = trig_hit(trg, ovf_evt, mat_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wave_q <= 1'b0;
    else if (!trig_active(trg)) wave_q <= 1'b0;
    else if (toggle)            wave_q <= wave_q ^ trig_evt;
    else                        wave_q <= trig_evt;
  end

  always_comb pwm_out = wave_q ^ idle_lvl;
endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
  import cct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt_q, load_q, mat_q, capt_q, cnt_nxt;
  logic [NFLAG-1:0] stat_q, ien_q, stat_set, stat_clr;

  logic wr_ctl, cnt_wr, wr_load, wr_mat, wr_stat, wr_ien;
  logic run, auto_rl, cmp_en, tick, at_max;
  logic ovf_evt, mat_evt, cap_evt, trig_evt, wave_q;

  always_comb begin
    wr_ctl  = bus_wr && (bus_addr == ADDR_W'(RA_CTL));
    cnt_wr  = bus_wr && (bus_addr == ADDR_W'(RA_CNT));
    wr_load = bus_wr && (bus_addr == ADDR_W'(RA_LOAD));
    wr_mat  = bus_wr && (bus_addr == ADDR_W'(RA_MAT));
    wr_stat = bus_wr && (bus_addr == ADDR_W'(RA_STAT));
    wr_ien  = bus_wr && (bus_addr == ADDR_W'(RA_IEN));
    run     = ctl_q[CB_RUN];
    auto_rl = ctl_q[CB_AR];
    cmp_en  = ctl_q[CB_CMP_EN];
  end

  cct_prescale #(.FLD_W(DIV_FLD_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_en  (ctl_q[CB_DIV_EN]),
    .div_sel (ctl_q[CB_DIV_LO +: DIV_FLD_W]),
    .tick    (tick)
  );

  // next count on a tick, and the events derived from it
  always_comb begin
    at_max  = &cnt_q;
    cnt_nxt = at_max ? (auto_rl ? load_q : '0) : cnt_q + 1'b1;
    ovf_evt = tick & at_max;
    mat_evt = tick & cmp_en & (cnt_nxt == mat_q);
  end

  cct_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (cap_in),
    .mode    (edge_sel_e'(ctl_q[CB_EDGE_LO +: 2])),
    .cap_evt (cap_evt)
  );

  cct_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .trg      (trig_sel_e'(ctl_q[CB_TRG_LO +: 2])),
    .toggle   (ctl_q[CB_TOGGLE]),
    .idle_lvl (ctl_q[CB_IDLE]),
    .ovf_evt  (ovf_evt),
    .mat_evt  (mat_evt),
    .trig_evt (trig_evt),
    .wave_q   (wave_q),
    .pwm_out  (pwm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctl_q <= '0;
    else if (wr_ctl)             ctl_q <= bus_wdata[CTL_W-1:0];
    else if (ovf_evt && !auto_rl) ctl_q[CB_RUN] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= bus_wdata;
    else if (tick)   cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      mat_q  <= '0;
      ien_q  <= '0;
      capt_q <= '0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      if (wr_mat)  mat_q  <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata[NFLAG-1:0];
      if (cap_evt) capt_q <= cnt_q;
    end
  end

  always_comb begin
    stat_set           = '0;
    stat_set[FL_MATCH] = mat_evt;
    stat_set[FL_OVF]   = ovf_evt;
    stat_set[FL_CAP]   = cap_evt;
    stat_clr           = wr_stat ? bus_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  always_comb irq = |(stat_q & ien_q);

  always_comb begin
    case (int'(bus_addr))
      RA_CTL:  bus_rdata = CNT_W'(ctl_q);
      RA_CNT:  bus_rdata = cnt_q;
      RA_LOAD: bus_rdata = load_q;
      RA_MAT:  bus_rdata = mat_q;
      RA_CAPT: bus_rdata = capt_q;
      RA_STAT: bus_rdata = CNT_W'(stat_q);
      RA_IEN:  bus_rdata = CNT_W'(ien_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
  parameter int CNT_W = 32,
  parameter int NF    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic [CNT_W-1:0] capt,
  input logic [NF-1:0]    stat,
  input logic             tick,
  input logic             auto_rl,
  input logic             cnt_wr,
  input logic             wr_ctl,
  input logic             ovf_evt,
  input logic             mat_evt,
  input logic             cap_evt,
  input logic             trig_evt,
  input logic             toggle,
  input logic             wave_q,
  input logic             irq
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf_evt && !cnt_wr) |=> cnt == $past(cnt) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> cnt == $past(cnt));

  assert_wrap_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !cnt_wr) |=> cnt == ($past(auto_rl) ? $past(load) : '0));

  assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat[1]);

  assert_match_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mat_evt |=> stat[0]);

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (stat[2] && capt == $past(cnt)));

  assert_pulse_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !trig_evt && !wr_ctl) |=> !wave_q);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !irq);
endmodule

bind cmpcap_timer cct_chk #(.CNT_W(CNT_W), .NF(cct_pkg::NFLAG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt_q),
  .load     (load_q),
  .capt     (capt_q),
  .stat     (stat_q),
  .tick     (tick),
  .auto_rl  (auto_rl),
  .cnt_wr   (cnt_wr),
  .wr_ctl   (wr_ctl),
  .ovf_evt  (ovf_evt),
  .mat_evt  (mat_evt),
  .cap_evt  (cap_evt),
  .trig_evt (trig_evt),
  .toggle   (ctl_q[cct_pkg::CB_TOGGLE]),
  .wave_q   (wave_q),
  .irq      (irq)
);

// File: tb/tb_cmpcap_timer.sv
`timescale 1ns/1ps
module tb_cmpcap_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cmpcap_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  localparam logic [2:0] A_CTL = 3'd0, A_CNT = 3'd1, A_LOAD = 3'd2, A_MAT = 3'd3,
                         A_CAPT = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] load;
    logic [31:0] mat;
    logic [31:0] start;
    logic [7:0]  waits;
    logic [31:0] exp_cnt;
    logic [2:0]  exp_stat;
    logic        exp_run;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{32'h01, 32'h0,   32'h0,  32'd10,        8'd5,  32'd15,  3'b000, 1'b1}, // R2
    '{32'h21, 32'h0,   32'h0,  32'd0,         8'd7,  32'd3,   3'b000, 1'b1}, // R3 /2
    '{32'h29, 32'h0,   32'h0,  32'd100,       8'd20, 32'd102, 3'b000, 1'b1}, // R3 /8
    '{32'h01, 32'h0,   32'h0,  32'hFFFFFFFE,  8'd3,  32'd0,   3'b010, 1'b0}, // R4 stop
    '{32'h03, 32'h100, 32'h0,  32'hFFFFFFFE,  8'd3,  32'h101, 3'b010, 1'b1}, // R4 reload
    '{32'h25, 32'h0,   32'h0,  32'hFFFFFFFF,  8'd4,  32'd0,   3'b010, 1'b0}, // R3/R4 /4
    '{32'h41, 32'h0,   32'd20, 32'd10,        8'd5,  32'd15,  3'b000, 1'b1}, // R5 not reached
    '{32'h01, 32'h0,   32'd12, 32'd10,        8'd5,  32'd15,  3'b000, 1'b1}, // R5 compare off
    '{32'h41, 32'h0,   32'd12, 32'd10,        8'd5,  32'd15,  3'b001, 1'b1}, // R5 match
    '{32'h43, 32'h50,  32'h50, 32'hFFFFFFFF,  8'd2,  32'h51,  3'b011, 1'b1}  // R4/R5 reload onto match
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 pwm reset", {31'b0, pwm_out}, 32'h0);

    // table walk: counting, prescaler, overflow, match
    for (int k = 0; k < NVEC; k++) begin
      wr(A_CTL, 32'h0);
      wr(A_STAT, 32'h7);
      wr(A_LOAD, VEC[k].load);
      wr(A_MAT, VEC[k].mat);
      wr(A_CNT, VEC[k].start);
      wr(A_CTL, VEC[k].ctl);
      waitn(int'(VEC[k].waits));
      rd(A_CNT, v);  check("R2/R3/R4 count", v, VEC[k].exp_cnt);
      rd(A_STAT, v); check("R4/R5 status", v, {29'b0, VEC[k].exp_stat});
      rd(A_CTL, v);  check("R4 run bit", {31'b0, v[0]}, {31'b0, VEC[k].exp_run});
    end

    // R8 / R9: status is 3 from the last vector
    wr(A_CTL, 32'h0);
    wr(A_IEN, 32'h2);
    check("R9 irq overflow enabled", {31'b0, irq}, 32'h1);
    wr(A_IEN, 32'h1);
    check("R9 irq match enabled", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R8 w1c match only", v, 32'h2);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R8 write zero keeps", v, 32'h2);
    wr(A_STAT, 32'h2);
    wr(A_IEN, 32'h0);
    rd(A_STAT, v); check("R8 w1c overflow", v, 32'h0);

    // R6 counter write overrides increment
    wr(A_CNT, 32'h0);
    wr(A_CTL, 32'h1);
    wr(A_CNT, 32'h500);
    rd(A_CNT, v); check("R6 write replaces increment", v, 32'h500);
    waitn(1);
    rd(A_CNT, v); check("R6 counts on after write", v, 32'h501);
    wr(A_CTL, 32'h0);
    waitn(3);
    rd(A_CNT, v); check("R2 stopped holds", v, 32'h502);

    // R7 capture edge selection
    wr(A_CNT, 32'h777);
    wr(A_CTL, 32'h100);
    cap_in = 1'b1;
    waitn(2);
    rd(A_STAT, v); check("R7 not yet captured", v, 32'h0);
    waitn(1);
    rd(A_CAPT, v); check("R7 rising capture", v, 32'h777);
    rd(A_STAT, v); check("R7 capture flag", v, 32'h4);
    wr(A_STAT, 32'h4);
    wr(A_CNT, 32'h888);
    cap_in = 1'b0; waitn(4);
    rd(A_CAPT, v); check("R7 fall ignored in rise mode", v, 32'h777);
    rd(A_STAT, v); check("R7 no flag on ignored edge", v, 32'h0);
    wr(A_CTL, 32'h200);
    cap_in = 1'b1; waitn(4);
    rd(A_CAPT, v); check("R7 rise ignored in fall mode", v, 32'h777);
    cap_in = 1'b0; waitn(4);
    rd(A_CAPT, v); check("R7 falling capture", v, 32'h888);
    wr(A_STAT, 32'h4);
    wr(A_CTL, 32'h0);
    wr(A_CNT, 32'h999);
    cap_in = 1'b1; waitn(4);
    cap_in = 1'b0; waitn(4);
    rd(A_CAPT, v); check("R7 mode 0 captures nothing", v, 32'h888);
    rd(A_STAT, v); check("R7 mode 0 no flag", v, 32'h0);
    wr(A_CTL, 32'h300);
    cap_in = 1'b1; waitn(4);
    rd(A_CAPT, v); check("R7 both-edge capture", v, 32'h999);
    wr(A_CTL, 32'h0);
    wr(A_STAT, 32'h7);

    // R12 idle level
    wr(A_CTL, 32'h80);
    check("R12 idle high", {31'b0, pwm_out}, 32'h1);
    wr(A_CTL, 32'h0);
    check("R12 idle low", {31'b0, pwm_out}, 32'h0);

    // R11 toggle on overflow (R10 trigger 1)
    wr(A_LOAD, 32'hFFFFFFFE);
    wr(A_CNT, 32'hFFFFFFFE);
    wr(A_CTL, 32'h1403);
    waitn(1); check("R11 toggle before event", {31'b0, pwm_out}, 32'h0);
    waitn(1); check("R11 first toggle", {31'b0, pwm_out}, 32'h1);
    waitn(1); check("R11 toggle holds", {31'b0, pwm_out}, 32'h1);
    waitn(1); check("R11 second toggle", {31'b0, pwm_out}, 32'h0);
    wr(A_CTL, 32'h0);

    // R10/R11 pulse on match
    wr(A_MAT, 32'd5);
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'h0841);
    waitn(1); check("R11 pulse idle", {31'b0, pwm_out}, 32'h0);
    waitn(1); check("R10 pulse on match", {31'b0, pwm_out}, 32'h1);
    waitn(1); check("R11 pulse one cycle", {31'b0, pwm_out}, 32'h0);
    wr(A_CTL, 32'h0);

    // R10 overflow-only trigger ignores match
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'h0441);
    waitn(2); check("R10 match ignored by trigger 1", {31'b0, pwm_out}, 32'h0);
    wr(A_CTL, 32'h0);

    // R10 trigger 3 behaves as none
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'h0C41);
    waitn(2); check("R10 trigger 3 inert", {31'b0, pwm_out}, 32'h0);
    wr(A_CTL, 32'h0);

    // R12 pulse with idle high
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'h08C1);
    waitn(2); check("R12 inverted pulse", {31'b0, pwm_out}, 32'h0);
    waitn(1); check("R12 back to idle high", {31'b0, pwm_out}, 32'h1);
    wr(A_CTL, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule